// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Sticky Wrap Flag

This block is a 16-bit up-counter that runs without stopping from the system clock. A power-of-two prescaler sits in front of it. Software enables the timer, picks a divide ratio from 1 to 128 with a 3-bit code, and reads the count over an 8-bit register bus. Each time the counter rolls from its top value back to zero, a sticky wrap flag is raised. The flag stays set until software writes a one to it. An interrupt line follows the flag while a local interrupt-enable bit is set.

The prescaler is a divide counter that produces a one-cycle tick. It only adopts a new divide code at a tick boundary, or while the timer is stopped, so a change of ratio never corrupts the count. The count is wider than the bus. Reading the high byte therefore captures the low byte in a holding register, and a later low-byte read returns that held value. The two halves together form one coherent 16-bit sample.

Top module: `psc_free_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `ovf_irq` is low. This covers the count, both control registers and the flag register, and the prescaler phase is cleared as well.
- R2: On every prescaler tick the count rises by exactly one, and it wraps from 0xFFFF to 0x0000. Between ticks the count holds its value.
- R3: Bits 2:0 of the divide register (address 3) hold the code N. While the timer is enabled, a tick occurs once every 2^N clock cycles. After the enable is written with the code already in place, the count equals floor(k / 2^N) k cycles later.
- R4: Bit 7 of the run register (address 2) is the enable. While it is 0 no tick occurs, the count holds, and the prescaler phase restarts from zero.
- R5: A new divide code written while the timer runs takes effect only after the next tick of the old ratio. While the timer is stopped, a new code takes effect at once.
- R6: Bit 7 of the flag register (address 4) becomes 1 in the cycle after a wrap. It becomes 1 at no other time.
- R7: A bus write of 1 to bit 7 of address 4 clears the flag. A write of 0 there leaves the flag unchanged.
- R8: If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R9: A read of address 0 returns count bits 15:8 and, at the same clock edge, copies count bits 7:0 into a holding register. A read of address 1 returns that held byte, not the live count.
- R10: `ovf_irq` is high exactly when the flag is set and bit 7 of address 3 (interrupt enable) is set.
- R11: Reads of address 2 return {enable, 7'b0}. Reads of address 3 return {interrupt enable, 4'b0, code}. Reads of address 4 return {flag, 7'b0}. Addresses 5 to 7 read as 0x00, and the count cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, drives prescaler and counter |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ovf_irq | output | 1 | Wrap interrupt request |

## Verification
Two pairs of events can share one cycle: a counter wrap with a software clear of the flag, and a high-byte read with a counter tick. A cycle-level reference model inside the bench tracks the count. The bench waits until the model shows 0xFFFF at divide-by-1, then issues the clearing write in exactly that cycle. It judges the outcome by reading back the flag and the interrupt line, both of which must show the flag still set. Randomized reads at divide-by-1 make high-byte captures land on ticking cycles, and every low-byte read is compared with the byte the model held at the capture edge.

// File: rtl/psc_timer_pkg.sv
package psc_timer_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int PH_W   = (1 << SEL_W) - 1;

  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_RUN    = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;

  // Bit 7 carries enable, interrupt enable and the flag in their registers.
  localparam int TOP_BIT = DATA_W - 1;

  typedef struct packed {
    logic             run;
    logic             irq_en;
    logic [SEL_W-1:0] code;
  } ctrl_t;

  // Last phase value of a 2^code divide.
  function automatic logic [PH_W-1:0] phase_last(input logic [SEL_W-1:0] code);
    logic [PH_W:0] span;
    span = (PH_W + 1)'(1) << code;
    return PH_W'(span - 1'b1);
  endfunction

endpackage

// File: rtl/psc_tick_gen.sv
module psc_tick_gen
  import psc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);

  logic [PH_W-1:0]  phase_q;
  logic [SEL_W-1:0] live_code_q;
  logic             at_last;

  assign at_last = (phase_q == phase_last(live_code_q));
  assign tick    = run && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= '0;
      live_code_q <= '0;
    end else if (!run || tick) begin
      phase_q     <= '0;
      live_code_q <= code;
    end else begin
      phase_q     <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/psc_count.sv
module psc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/psc_regs.sv
module psc_regs
  import psc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              flag_clr,
  output logic              irq
);

  localparam int HI_W = CNT_W - DATA_W;

  ctrl_t             ctrl_q;
  logic              flag_q;
  logic [DATA_W-1:0] lo_hold_q;
  logic              wr_run, wr_div, rd_hi;
  logic              unused_wbits;

  assign wr_run   = bus_sel &&  bus_wr && (bus_addr == A_RUN);
  assign wr_div   = bus_sel &&  bus_wr && (bus_addr == A_DIV);
  assign flag_clr = bus_sel &&  bus_wr && (bus_addr == A_FLAG) && bus_wdata[TOP_BIT];
  assign rd_hi    = bus_sel && !bus_wr && (bus_addr == A_CNT_HI);
  assign unused_wbits = ^bus_wdata[TOP_BIT-1:SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      lo_hold_q <= '0;
    end else begin
      if (wr_run) ctrl_q.run <= bus_wdata[TOP_BIT];
      if (wr_div) begin
        ctrl_q.irq_en <= bus_wdata[TOP_BIT];
        ctrl_q.code   <= bus_wdata[SEL_W-1:0];
      end
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (rd_hi) lo_hold_q <= cnt[DATA_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_HI: bus_rdata = DATA_W'(cnt[CNT_W-1 -: HI_W]);
      A_CNT_LO: bus_rdata = lo_hold_q;
      A_RUN:    bus_rdata[TOP_BIT] = ctrl_q.run;
      A_DIV: begin
        bus_rdata[TOP_BIT]     = ctrl_q.irq_en;
        bus_rdata[SEL_W-1:0]   = ctrl_q.code;
      end
      A_FLAG:   bus_rdata[TOP_BIT] = flag_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;
  assign irq  = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/psc_free_timer.sv
module psc_free_timer
  import psc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ovf_irq
);

  ctrl_t            ctrl;
  logic             tick;
  logic             wrap_evt;
  logic             flag;
  logic             flag_clr;
  logic [CNT_W-1:0] cnt;

  psc_tick_gen u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl.run),
    .code  (ctrl.code),
    .tick  (tick)
  );

  psc_count #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .cnt   (cnt),
    .wrap  (wrap_evt)
  );

  psc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .wrap      (wrap_evt),
    .ctrl      (ctrl),
    .flag      (flag),
    .flag_clr  (flag_clr),
    .irq       (ovf_irq)
  );

endmodule

// File: rtl/psc_timer_chk.sv
module psc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             irq_en,
  input logic             tick,
  input logic             wrap_evt,
  input logic             flag,
  input logic             flag_clr,
  input logic             irq,
  input logic [CNT_W-1:0] cnt
);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == '0);

  // R4
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap_evt));

  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !wrap_evt) |=> !flag);

  // R10
  irq_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && irq_en));

  // R10
  irq_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en) |-> irq);

endmodule

bind psc_free_timer psc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (ctrl.run),
  .irq_en   (ctrl.irq_en),
  .tick     (tick),
  .wrap_evt (wrap_evt),
  .flag     (flag),
  .flag_clr (flag_clr),
  .irq      (ovf_irq),
  .cnt      (cnt)
);

// File: tb/psc_free_timer_bench.sv
`timescale 1ns/1ps
module psc_free_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psc_free_timer u_psc_free_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_irq(ovf_irq)
  );

  // Reference model written from the requirements.
  logic        m_run, m_ie, m_flag;
  logic [2:0]  m_code, m_live;
  logic [6:0]  m_ph;
  logic [15:0] m_cnt;
  logic [7:0]  m_hold;

  function automatic bit ref_tick(input logic run, input logic [6:0] ph,
                                  input logic [2:0] live);
    return run && ((32'(ph) + 1) == (32'd1 << live));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_ie <= 0; m_flag <= 0; m_code <= 0; m_live <= 0;
      m_ph <= 0; m_cnt <= 0; m_hold <= 0;
    end else begin
      automatic bit tk  = ref_tick(m_run, m_ph, m_live);
      automatic bit wr  = bus_sel && bus_wr;
      automatic bit rd  = bus_sel && !bus_wr;
      if (!m_run || tk) begin m_ph <= 0; m_live <= m_code; end
      else m_ph <= m_ph + 1;
      if (tk) m_cnt <= m_cnt + 1;
      if (tk && m_cnt == 16'hFFFF) m_flag <= 1;
      else if (wr && bus_addr == 3'd4 && bus_wdata[7]) m_flag <= 0;
      if (wr && bus_addr == 3'd2) m_run <= bus_wdata[7];
      if (wr && bus_addr == 3'd3) begin m_ie <= bus_wdata[7]; m_code <= bus_wdata[2:0]; end
      if (rd && bus_addr == 3'd0) m_hold <= m_cnt[7:0];
    end
  end

  function automatic logic [7:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[15:8];
      3'd1: return m_hold;
      3'd2: return {m_run, 7'b0};
      3'd3: return {m_ie, 4'b0, m_code};
      3'd4: return {m_flag, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R9";
      3'd4: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // R10: interrupt line checked every cycle against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      n_cmp++;
      if (ovf_irq !== (m_flag && m_ie)) begin
        n_bad++;
        $display("FAIL R10 actual=%0b expected=%0b at %0t", ovf_irq, m_flag && m_ie, $time);
      end
    end
  end

  task automatic drive_now(input bit s, input bit w, input logic [2:0] a, input logic [7:0] d);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); drive_now(1, 1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); drive_now(0, 0, 3'd0, 8'h00); end
  endtask

  task automatic rd_reg(input logic [2:0] a, input string req, output logic [7:0] got);
    @(negedge clk); drive_now(1, 0, a, 8'h00);
    #1; got = bus_rdata;
    check(req, got, ref_read(a));
  endtask

  task automatic rd_count(input string req, output logic [15:0] v);
    logic [7:0] h, l;
    rd_reg(3'd0, req, h);
    rd_reg(3'd1, req, l);
    v = {h, l};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v0, v1;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), "R1", b);
      check("R1", b, 8'h00);
    end
    n_cmp++;
    if (ovf_irq !== 1'b0) begin n_bad++; $display("FAIL R1 actual=%0b expected=0", ovf_irq); end

    // R3: code 2 then enable; 37 cycles later count = floor(37/4) = 9
    wr_reg(3'd3, 8'h02);
    wr_reg(3'd2, 8'h80);
    idle(37);
    rd_count("R3", v0);
    check("R3", v0[7:0], 8'd9);
    check("R3", v0[15:8], 8'd0);

    // R4: stop holds the count
    wr_reg(3'd2, 8'h00);
    rd_count("R4", v0);
    idle(30);
    rd_count("R4", v1);
    check("R4", v1[7:0], v0[7:0]);
    check("R4", v1[15:8], v0[15:8]);

    // R5: change code while running at divide 8
    wr_reg(3'd3, 8'h03);
    wr_reg(3'd2, 8'h80);
    idle(11);
    wr_reg(3'd3, 8'h00);
    for (int i = 0; i < 8; i++) rd_reg(3'd0, "R5", b);
    rd_reg(3'd1, "R5", b);

    // R9: held low byte survives while counting at divide 1
    rd_reg(3'd0, "R9", b);
    idle(5);
    rd_reg(3'd1, "R9", b);

    // R11: control read-back and writes to the count ignored
    wr_reg(3'd3, 8'hFD);
    rd_reg(3'd3, "R11", b);
    check("R11", b, 8'h85);
    wr_reg(3'd0, 8'hAA);
    wr_reg(3'd1, 8'h55);
    rd_count("R11", v0);

    // Randomized traffic, checked against the model.
    for (int i = 0; i < 500; i++) begin
      automatic int op = $urandom_range(0, 9);
      automatic logic [2:0] a = 3'($urandom_range(0, 7));
      case (op)
        0: wr_reg(3'd2, 8'($urandom));
        1: wr_reg(3'd3, 8'($urandom));
        2: wr_reg(3'd4, 8'($urandom));
        3, 4: idle($urandom_range(1, 20));
        5: rd_count("R9", v0);
        default: rd_reg(a, req_of(a), b);
      endcase
    end

    // R8: wrap and clearing write land in the same cycle
    wr_reg(3'd3, 8'h80);
    wr_reg(3'd2, 8'h80);
    idle(2);
    @(negedge clk);
    while (!(m_cnt == 16'hFFFF && m_run && m_live == 3'd0)) begin
      drive_now(0, 0, 3'd0, 8'h00);
      @(negedge clk);
    end
    drive_now(1, 1, 3'd4, 8'h80);
    rd_reg(3'd4, "R8", b);
    check("R8", b, 8'h80);
    n_cmp++;
    if (ovf_irq !== 1'b1) begin n_bad++; $display("FAIL R10 actual=%0b expected=1", ovf_irq); end
    rd_count("R2", v0);

    // R7: writing zero keeps the flag, writing one clears it
    wr_reg(3'd4, 8'h7F);
    rd_reg(3'd4, "R7", b);
    check("R7", b, 8'h80);
    wr_reg(3'd4, 8'h80);
    rd_reg(3'd4, "R7", b);
    check("R7", b, 8'h00);
    idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule